// File: doc/BRIEF.md
# Register-Driven Two-Wire Serial EEPROM Slave

This block behaves as a small serial EEPROM on a two-wire bus that a host toggles in software. The host owns one register. Each write to it sets the data-line and clock-line levels. Each read returns the level of the shared data line as the slave sees it. The protocol logic takes exactly one step per register write, so the bus runs at whatever pace the host's writes set, and the system clock only registers state.

A transaction opens with a start condition and then a select byte. The select byte holds a four-bit type field, which is ignored, three device-address bits, which are captured but do not change which byte is accessed, and a direction flag. A write transaction carries a one-byte word address and then data bytes. Each data bit lands in storage as soon as it is clocked in. The address advances inside a page and wraps within that page. A read transaction returns bytes from the current word address, and the address advances over the whole array. To read from a chosen address, the host sends a write with only the word address, then a repeated start with a read select byte. Storage is a 256-byte array by default.

Top module: `eep_slave`

## Requirements
- R1: After reset, the data line reads 1 (both lines taken as high), the block is idle, and bit 0 of `reg_rdata` always reads 0.
- R2: A write to the register takes the data level from `reg_wdata` bit 0 and the clock level from bit 1, and advances the protocol by one step. Without a write, no state changes, and the line is returned on `reg_rdata` bit 1.
- R3: A start condition (data falls while clock is high) clears the bit count and enters device select. This holds in every state except wait-for-stop, including in the middle of a data byte, and the word address is kept.
- R4: A stop condition (data rises while clock is high) returns the block to idle. From idle, clock pulses get no acknowledge and leave storage unchanged.
- R5: In device select, a clock rising edge arms the bit count. The following eight falling edges take the four ignored type bits, then three device-address bits (MSB first), then the direction flag (1 = read, 0 = write), each using the data level held before that edge. The device-address bits do not affect which byte is accessed.
- R6: During the ninth clock of the select, word-address and write-data bytes, the slave drives the line to 0 as an acknowledge.
- R7: After the write select byte, the next 8 bits form the word address, MSB first. After its acknowledge, the address is masked to the array size and write-data begins.
- R8: In write-data, each bit updates its bit of the addressed byte in storage at once, MSB first. A byte that is cut short by a stop or a start keeps only the bits already received.
- R9: After each full written byte, only the low PAGE_W address bits increment, wrapping within the page. The upper bits stay fixed.
- R10: In read-data, bits 1 to 8 present the addressed byte MSB first. After the eighth bit, the address increments, wrapping from the top of the array to 0.
- R11: A high data level on the ninth clock of a read byte (no acknowledge) enters wait-for-stop. That state ignores start conditions and never drives the line, and it leaves only on a stop.
- R12: Whenever the slave is not presenting a read bit or an acknowledge, the line equals the last data level the host wrote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_wdata | input | 2 | Bit 0 data-line level, bit 1 clock-line level |
| reg_rdata | output | 2 | Bit 1 data-line level seen by the host, bit 0 reads 0 |

## Verification
A wrong internal state surfaces at the line level within one register write of the protocol step that caused it. A miscounted bit shows up as a missing or misplaced acknowledge on the ninth clock, and a wrong address or storage bit appears as a wrong read bit on the next read. Storage is filled completely through page writes, using several type and device-address patterns, and then read back in full. Separate checks cover page wrap, array wrap, partial bytes cut by a stop or a restart, and the wait-for-stop state, so that a fault in any of these paths shows up as a data or acknowledge mismatch.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int CNT_W  = 4;
    localparam int WORD_W = 8;
    localparam int DEV_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SEL,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA
    } state_e;

    typedef struct packed {
        state_e              state;
        logic [CNT_W-1:0]    cnt;
        logic [WORD_W-1:0]   word;
        logic [DEV_W-1:0]    dev;
        logic                rw;
        logic                sda;
        logic                scl;
    } ctrl_t;
endpackage

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bit_sel,
    input  logic              val,
    output logic              rd_bit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr][bit_sel] <= val;
    end

    assign rd_bit = mem[addr][bit_sel];

    // R8
    bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(addr)][$past(bit_sel)] == $past(val));
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              rd_bit,
    output logic              line,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_bit,
    output logic              mem_val
);
    localparam logic [WORD_W-1:0] AMASK = WORD_W'((1 << ADDR_W) - 1);
    localparam logic [WORD_W-1:0] PMASK = WORD_W'((1 << PAGE_W) - 1);

    ctrl_t q, d;
    logic fall, rise, start_ev, stop_ev;
    logic [CNT_W-1:0] sh, dsh;

    always_comb begin
        fall     = upd & q.scl & ~scl_in;
        rise     = upd & ~q.scl & scl_in;
        start_ev = upd & scl_in & q.sda & ~sda_in;
        stop_ev  = upd & scl_in & ~q.sda & sda_in;
        sh       = CNT_W'(8) - q.cnt;
        dsh      = CNT_W'(7) - q.cnt;
        d        = q;
        mem_we   = 1'b0;
        if (upd) begin
            d.sda = sda_in;
            d.scl = scl_in;
        end
        if (start_ev && q.state != ST_HOLD) begin
            d.state = ST_SEL;
            d.cnt   = '0;
        end else if (stop_ev) begin
            d.state = ST_IDLE;
        end else begin
            case (q.state)
                ST_SEL: begin
                    if (rise && q.cnt == '0) begin
                        d.cnt = CNT_W'(1);
                    end else if (fall && q.cnt != '0) begin
                        if (q.cnt <= CNT_W'(4)) begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end else if (q.cnt <= CNT_W'(7)) begin
                            d.dev[dsh[1:0]] = q.sda;
                            d.cnt = q.cnt + CNT_W'(1);
                        end else if (q.cnt == CNT_W'(8)) begin
                            d.rw  = q.sda;
                            d.cnt = q.cnt + CNT_W'(1);
                        end else begin
                            d.cnt   = CNT_W'(1);
                            d.state = q.rw ? ST_RDATA : ST_WADDR;
                        end
                    end
                end
                ST_WADDR: begin
                    if (fall) begin
                        if (q.cnt < CNT_W'(9)) begin
                            d.word[sh[2:0]] = q.sda;
                            d.cnt = q.cnt + CNT_W'(1);
                        end else begin
                            d.cnt   = CNT_W'(1);
                            d.word  = q.word & AMASK;
                            d.state = ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (fall) begin
                        if (q.cnt < CNT_W'(9)) begin
                            mem_we = 1'b1;
                            d.cnt  = q.cnt + CNT_W'(1);
                            if (q.cnt == CNT_W'(8))
                                d.word = (q.word & ~PMASK) | ((q.word + WORD_W'(1)) & PMASK);
                        end else begin
                            d.cnt = CNT_W'(1);
                        end
                    end
                end
                ST_RDATA: begin
                    if (fall) begin
                        if (q.cnt < CNT_W'(9)) begin
                            d.cnt = q.cnt + CNT_W'(1);
                            if (q.cnt == CNT_W'(8))
                                d.word = (q.word + WORD_W'(1)) & AMASK;
                        end else begin
                            d.cnt = CNT_W'(1);
                            if (q.sda) d.state = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        line = q.sda;
        case (q.state)
            ST_RDATA: if (q.cnt >= CNT_W'(1) && q.cnt <= CNT_W'(8)) line = rd_bit;
            ST_SEL, ST_WADDR, ST_WDATA: if (q.cnt == CNT_W'(9)) line = 1'b0;
            default: ;
        endcase
    end

    assign mem_addr = q.word[ADDR_W-1:0];
    assign mem_bit  = sh[2:0];
    assign mem_val  = q.sda;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, word: '0, dev: '0,
                   rw: 1'b0, sda: 1'b1, scl: 1'b1};
        end else begin
            q <= d;
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q));
    // R3
    start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && scl_in && q.sda && !sda_in && q.state != ST_HOLD)
        |=> (q.state == ST_SEL && q.cnt == '0));
    // R4
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && scl_in && !q.sda && sda_in) |=> q.state == ST_IDLE);
    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(9));
    // R9
    page_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && q.state == ST_WDATA && q.scl && !scl_in && q.cnt == CNT_W'(8))
        |=> ((q.word >> PAGE_W) == ($past(q.word) >> PAGE_W)));
endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_wdata,
    output logic [1:0] reg_rdata
);
    logic              line;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [2:0]        mem_bit;
    logic              mem_val;
    logic              rd_bit;

    eep_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (reg_wr),
        .sda_in   (reg_wdata[0]),
        .scl_in   (reg_wdata[1]),
        .rd_bit   (rd_bit),
        .line     (line),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_bit  (mem_bit),
        .mem_val  (mem_val)
    );

    eep_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .addr    (mem_addr),
        .bit_sel (mem_bit),
        .val     (mem_val),
        .rd_bit  (rd_bit)
    );

    assign reg_rdata = {line, 1'b0};
endmodule

// File: tb/eep_slave_test.sv
module eep_slave_test;
    localparam int PAGE_W = 4;
    localparam int PAGE   = 1 << PAGE_W;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [1:0] reg_wdata;
    logic [1:0] reg_rdata;

    always #10 clk = ~clk;

    eep_slave #(.ADDR_W(8), .PAGE_W(PAGE_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int runs = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    task automatic chk(input string req, input int act, input int exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input bit s, input bit c);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = {c, s};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic start_c; put(1,0); put(1,1); put(0,1); put(0,0); endtask
    task automatic stop_c;  put(0,0); put(0,1); put(1,1); endtask
    task automatic send_bit(input bit b); put(b,0); put(b,1); put(b,0); endtask

    task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        put(1,0);
        chk(req, int'(reg_rdata[1]), int'(exp_ack));
        put(1,1);
        put(1,0);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit nack);
        for (int i = 7; i >= 0; i--) begin
            v[i] = reg_rdata[1];
            put(1,1);
            put(1,0);
        end
        put(nack,0); put(nack,1); put(nack,0); put(1,0);
    endtask

    task automatic wr_bytes(input logic [6:0] sel, input logic [7:0] a, input int n, input int seed);
        start_c;
        send_byte({sel, 1'b0}, 1'b0, "R6");
        send_byte(a, 1'b0, "R7");
        for (int k = 0; k < n; k++) begin
            logic [7:0] dv;
            dv = 8'(seed + k * 29);
            send_byte(dv, 1'b0, "R6");
            model[(a & 8'(~(PAGE - 1))) | 8'((int'(a) + k) % PAGE)] = dv;
        end
        stop_c;
    endtask

    task automatic rd_bytes(input logic [6:0] sel, input logic [7:0] a, input int n, input string req);
        logic [7:0] v;
        start_c;
        send_byte({sel, 1'b0}, 1'b0, "R5");
        send_byte(a, 1'b0, "R7");
        start_c;
        send_byte({sel, 1'b1}, 1'b0, "R5");
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k == n - 1);
            chk(req, int'(v), int'(model[8'(int'(a) + k)]));
        end
        stop_c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0;
        reg_wr = 1'b0;
        reg_wdata = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 line high", int'(reg_rdata[1]), 1);
        chk("R1 bit0 zero", int'(reg_rdata[0]), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(reg_rdata[1]), 1);

        // R12: idle line follows host data level
        put(0,0);
        chk("R12 follow low", int'(reg_rdata[1]), 0);
        put(1,0);
        chk("R12 follow high", int'(reg_rdata[1]), 1);
        chk("R2 bit0 zero", int'(reg_rdata[0]), 0);

        // R2: idle gaps without writes keep the protocol where it is
        start_c;
        repeat (20) @(negedge clk);
        chk("R2 no change w/o write", int'(reg_rdata[1]), 0);
        send_byte(8'hA0, 1'b0, "R2 select after gap");
        stop_c;

        // R5/R9 exhaustive fill, varied type and device bits
        for (int p = 0; p < 256 / PAGE; p++)
            wr_bytes({4'(p), 3'(p * 3)}, 8'(p * PAGE), PAGE, p * 7 + 1);
        rd_bytes(7'h50, 8'h00, 256, "R10 full read");
        rd_bytes(7'h50, 8'hFF, 2, "R10 array wrap");

        // R9 page wrap
        wr_bytes(7'h50, 8'h2C, 20, 99);
        rd_bytes(7'h50, 8'h20, PAGE, "R9 page wrap");

        // R5 device bits do not select storage
        wr_bytes(7'b0000_101, 8'h80, 1, 200);
        rd_bytes(7'b1111_000, 8'h80, 1, "R5 dev bits ignored");

        // R8 partial byte cut by stop
        start_c;
        send_byte(8'hA0, 1'b0, "R6");
        send_byte(8'h40, 1'b0, "R7");
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        stop_c;
        model[8'h40] = {4'b1010, model[8'h40][3:0]};
        rd_bytes(7'h50, 8'h40, 1, "R8 partial byte");

        // R3 restart in mid-byte keeps address
        start_c;
        send_byte(8'hA0, 1'b0, "R6");
        send_byte(8'h55, 1'b0, "R7");
        send_bit(0); send_bit(1); send_bit(1);
        model[8'h55] = {3'b011, model[8'h55][4:0]};
        start_c;
        send_byte(8'hA1, 1'b0, "R3 select after restart");
        recv_byte(v, 1'b1);
        chk("R3 restart read", int'(v), int'(model[8'h55]));
        stop_c;

        // R4 clocks after stop: no ack, no storage change
        put(1,0);
        send_byte(8'hA0, 1'b1, "R4 no ack when idle");
        send_byte(8'h00, 1'b1, "R4 no ack when idle");
        rd_bytes(7'h50, 8'h00, 1, "R4 storage unchanged");

        // R11 no-ack enters wait-for-stop
        start_c;
        send_byte(8'hA0, 1'b0, "R6");
        send_byte(8'h10, 1'b0, "R7");
        start_c;
        send_byte(8'hA1, 1'b0, "R5");
        recv_byte(v, 1'b1);
        chk("R10 read data", int'(v), int'(model[8'h10]));
        put(0,0);
        chk("R11 line follows low", int'(reg_rdata[1]), 0);
        put(1,0);
        chk("R11 line follows high", int'(reg_rdata[1]), 1);
        start_c;
        send_byte(8'hA0, 1'b1, "R11 start ignored, no ack");
        stop_c;
        rd_bytes(7'h50, 8'h10, 1, "R11 resumes after stop");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule